// File: doc/BRIEF.md
# Programmable Clock Burst Generator

This block produces a requested number of single-cycle clock-enable pulses toward a configuration interface. A typical use is the short run of extra clocks a target device needs once its configuration data has been delivered, for example a run of four. Software writes a pulse count over a 32-bit register bus, and that write alone starts the burst. The pulses come out on consecutive cycles, and the count register always reads the number still to go.

When the last pulse has been emitted, a sticky completion bit in the status register is set. Software clears that bit by writing a one to it. The expected sequence is to clear the bit, write the count, poll until the bit is set, and clear it again. A count of zero emits no pulses and reports completion one cycle later. A new count written while a burst is running restarts the burst from the new value.

Top module: `pulse_burst_gen`

## Requirements
- R1: After synchronous reset, the count register (offset 0x0) and the status register (offset 0x4) read 0 and `pulse_en` is low.
- R2: A bus write to offset 0x0 loads the low `CNT_W` bits of the write data as the pulse count N, and the upper data bits are ignored. `pulse_en` is then high on exactly N consecutive cycles, starting the cycle after the write edge.
- R3: The count register reads the number of pulses still to be emitted, including the current one. The value drops by one per pulse cycle and stays at 0 when idle.
- R4: Status bit 0 (done) becomes 1 on the clock edge that ends the last pulse. That is the same cycle in which the count first reads 0.
- R5: Once set, done stays 1 until it is cleared by software or by a count write.
- R6: Writing data with bit 0 = 1 to offset 0x4 clears done. Writing bit 0 = 0 leaves done unchanged, whatever the other data bits are.
- R7: Writing a count of 0 emits no pulse. Done reads 0 in the cycle after the write and 1 from the following cycle on.
- R8: A count write during an active burst restarts the burst with the new value, and only the new number of pulses follows.
- R9: Any count write clears done in the cycle after the write edge.
- R10: Reads of offsets other than 0x0 and 0x4 return 0, and status bits 31:1 read 0.
- R11: If a clear of done and the end of the last pulse happen on the same edge, done ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pulse_en | output | 1 | Single-cycle clock-enable pulses of the burst |

## Verification
Bursts of every length from 1 to 24 are checked cycle by cycle, together with one long burst. This separates an off-by-one in the pulse count from a wrong readback value or a done bit that sets one cycle early or late. A count written with nonzero upper bits shows that those bits are truncated. A zero count, a restart in the middle of a burst, and a count write over a set done bit each exercise one load path. A clear issued on the final pulse edge isolates the set-over-clear priority. Status writes with bit 0 low but other bits high confirm that only bit 0 acts.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

    localparam int unsigned BUS_W      = 32;
    localparam int unsigned OFS_COUNT  = 0;
    localparam int unsigned OFS_STATUS = 4;
    localparam int unsigned DONE_BIT   = 0;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_NONE   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic load;     // count register written
        logic clr_req;  // status write with clear bit set
    } bus_ctl_t;

    function automatic reg_sel_e decode_sel(input logic [BUS_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            BUS_W'(OFS_COUNT):  s = SEL_COUNT;
            BUS_W'(OFS_STATUS): s = SEL_STATUS;
            default:            s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pbg_decode.sv
module pbg_decode #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [pbg_pkg::BUS_W-1:0]  bus_wdata,
    output pbg_pkg::reg_sel_e          sel,
    output pbg_pkg::bus_ctl_t          ctl,
    output logic [CNT_W-1:0]           load_val
);
    import pbg_pkg::*;

    logic [BUS_W-1:0] ofs;

    always_comb begin
        ofs         = BUS_W'(bus_addr);
        sel         = decode_sel(ofs);
        ctl.load    = bus_wr && (sel == SEL_COUNT);
        ctl.clr_req = bus_wr && (sel == SEL_STATUS) && bus_wdata[DONE_BIT];
        load_val    = bus_wdata[CNT_W-1:0];
    end

endmodule

// File: rtl/pbg_counter.sv
module pbg_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] remaining,
    output logic             pulse,
    output logic             finish
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;
    logic             zero_q;   // a zero count was loaded last cycle

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            zero_q <= 1'b0;
        end else if (load) begin
            rem_q  <= load_val;
            zero_q <= (load_val == '0);
        end else begin
            zero_q <= 1'b0;
            if (rem_q != '0) begin
                rem_q <= rem_q - ONE;
            end
        end
    end

    always_comb begin
        remaining = rem_q;
        pulse     = (rem_q != '0);
        finish    = zero_q || (rem_q == ONE);
    end

endmodule

// File: rtl/pbg_status.sv
module pbg_status (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic finish,
    input  logic clr_req,
    output logic done
);
    logic done_q;

    // a count write clears, completion beats a software clear
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (load) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end else if (clr_req) begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;

endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pulse_en
);
    import pbg_pkg::*;

    reg_sel_e         sel;
    bus_ctl_t         ctl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] rem_q;
    logic             finish;
    logic             done_q;

    pbg_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .sel      (sel),
        .ctl      (ctl),
        .load_val (load_val)
    );

    pbg_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .load_val (load_val),
        .remaining(rem_q),
        .pulse    (pulse_en),
        .finish   (finish)
    );

    pbg_status u_status (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.load),
        .finish (finish),
        .clr_req(ctl.clr_req),
        .done   (done_q)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_COUNT:  bus_rdata[CNT_W-1:0] = rem_q;
            SEL_STATUS: bus_rdata[DONE_BIT]  = done_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pbg_checker.sv
module pbg_checker #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              pulse_en,
    input logic [CNT_W-1:0]  rem,
    input logic              done
);
    logic [31:0] ofs;
    logic        cnt_wr;
    logic        w1c;

    always_comb begin
        ofs    = 32'(bus_addr);
        cnt_wr = bus_wr && (ofs == 32'(pbg_pkg::OFS_COUNT));
        w1c    = bus_wr && (ofs == 32'(pbg_pkg::OFS_STATUS)) && bus_wdata[0];
    end

    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> rem == $past(bus_wdata[CNT_W-1:0]));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && rem != '0) |=> rem == $past(rem) - CNT_W'(1));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && rem == '0) |=> (rem == '0 && !pulse_en));

    assert_done_on_last_R4: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && rem == CNT_W'(1)) |=> done);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !cnt_wr && !w1c) |=> done);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (w1c && done) |=> !done);

    assert_zero_done_R7: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && $past(cnt_wr) && $past(bus_wdata[CNT_W-1:0]) == '0) |=> done);

    assert_load_clears_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !done);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (w1c && rem == CNT_W'(1)) |=> done);

endmodule

bind pulse_burst_gen pbg_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pulse_en (pulse_en),
    .rem      (rem_q),
    .done     (done_q)
);

// File: tb/pulse_burst_gen_tb.sv
module pulse_burst_gen_tb;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              pulse_en;

    int total = 0;
    int fails = 0;

    pulse_burst_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pulse_en (pulse_en)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr  = a[ADDR_W-1:0];
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a[ADDR_W-1:0];
        #1;
        d = bus_rdata;
    endtask

    // expects done clear on entry; leaves done clear on exit
    task automatic run_burst(input int n, input logic [31:0] d);
        logic [31:0] v;
        wr(32'h0, d);
        for (int j = 0; j < n; j++) begin
            rd(32'h0, v);
            chk("R3 remaining", v, 32'(n - j));
            chk("R2 pulse high", 32'(pulse_en), 32'd1);
            rd(32'h4, v);
            chk("R4 done low during burst", v, 32'd0);
            @(negedge clk);
        end
        chk("R2 pulse low after burst", 32'(pulse_en), 32'd0);
        rd(32'h0, v);
        chk("R3 count zero after burst", v, 32'd0);
        rd(32'h4, v);
        chk("R4 done after burst", v, 32'd1);
        repeat (3) @(negedge clk);
        rd(32'h4, v);
        chk("R5 done sticky", v, 32'd1);
        wr(32'h4, 32'h0);
        rd(32'h4, v);
        chk("R6 write zero ignored", v, 32'd1);
        wr(32'h4, 32'hFFFF_FFFE);
        rd(32'h4, v);
        chk("R6 upper bits ignored", v, 32'd1);
        wr(32'h4, 32'h1);
        rd(32'h4, v);
        chk("R6 clear", v, 32'd0);
    endtask

    initial begin
        #3_000_000;
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 pulse low", 32'(pulse_en), 32'd0);
        rd(32'h0, v);
        chk("R1 count zero", v, 32'd0);
        rd(32'h4, v);
        chk("R1 done zero", v, 32'd0);

        // R2/R3/R4 sweep of burst lengths
        for (int n = 1; n <= 24; n++) run_burst(n, 32'(n));
        run_burst(200, 32'd200);
        // R2 upper data bits truncated
        run_burst(3, 32'hABCD_0003);

        // R7 zero count
        wr(32'h0, 32'h0);
        chk("R7 no pulse", 32'(pulse_en), 32'd0);
        rd(32'h4, v);
        chk("R7 done low first cycle", v, 32'd0);
        @(negedge clk);
        chk("R7 still no pulse", 32'(pulse_en), 32'd0);
        rd(32'h4, v);
        chk("R7 done set", v, 32'd1);
        rd(32'h0, v);
        chk("R7 count zero", v, 32'd0);
        wr(32'h4, 32'h1);

        // R8 restart during burst
        wr(32'h0, 32'd10);
        repeat (3) @(negedge clk);
        wr(32'h0, 32'd5);
        rd(32'h4, v);
        chk("R8 done low after restart", v, 32'd0);
        for (int j = 0; j < 5; j++) begin
            rd(32'h0, v);
            chk("R8 remaining", v, 32'(5 - j));
            chk("R8 pulse high", 32'(pulse_en), 32'd1);
            @(negedge clk);
        end
        chk("R8 pulse low", 32'(pulse_en), 32'd0);
        rd(32'h4, v);
        chk("R8 done after restart", v, 32'd1);

        // R9 count write clears set done
        wr(32'h0, 32'd3);
        rd(32'h4, v);
        chk("R9 done cleared by count write", v, 32'd0);
        repeat (3) @(negedge clk);
        rd(32'h4, v);
        chk("R9 done after burst", v, 32'd1);
        wr(32'h4, 32'h1);

        // R11 clear on the final pulse edge
        wr(32'h0, 32'd2);
        @(negedge clk);
        wr(32'h4, 32'h1);
        rd(32'h4, v);
        chk("R11 set wins over clear", v, 32'd1);
        chk("R11 pulse low", 32'(pulse_en), 32'd0);
        wr(32'h4, 32'h1);

        // R10 unmapped offsets
        rd(32'h8, v);
        chk("R10 offset 8", v, 32'd0);
        rd(32'hC, v);
        chk("R10 offset C", v, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule